// File: doc/BRIEF.md
# Asynchronous Byte-Port Host Controller

This block sits on the host side of an external FIFO device that exchanges bytes over an asynchronous 8-bit parallel port. The port has one bidirectional data bus and two strobes, one for reads and one for writes. Two active-low status flags from the device gate the transfers. One flag reports that received data is waiting. The other reports that there is room to accept a byte. Toward the system the controller offers two byte streams with a valid/ready handshake, one for received bytes and one for bytes to transmit.

Both flags pass through multi-flop synchronizers. A state machine then sequences every transfer. The states are `ST_IDLE`, `ST_RD_STROBE`, `ST_WR_SETUP`, `ST_WR_STROBE`, `ST_WR_HOLD` and `ST_RECOVER`. The transitions are:

- From `ST_IDLE`, a read grant goes to `ST_RD_STROBE` and a write grant goes to `ST_WR_SETUP`.
- `ST_RD_STROBE` goes to `ST_RECOVER` when its timer expires.
- `ST_WR_SETUP` goes to `ST_WR_STROBE` after one cycle.
- `ST_WR_STROBE` goes to `ST_WR_HOLD` when its timer expires.
- `ST_WR_HOLD` goes to `ST_RECOVER` after one cycle.
- `ST_RECOVER` goes to `ST_IDLE` when its timer expires.

The flags are ignored in every state except `ST_IDLE`. The host drives the bus only in the three write states. When a read and a write are both possible, a round-robin arbiter alternates between them.

The pin drivers outside the block build the tri-state bus from `bus_out` and `bus_oe`. The timing is set by parameters given in clock cycles:

- `STROBE_ACT_CYC` sets the active strobe width.
- `STROBE_REST_CYC` sets the minimum inactive gap.
- `FLAG_RECOV_CYC` sets the flag recovery count.
- `SYNC_STAGES` sets the synchronizer depth.

Each timing value is raised to at least 2. The recovery wait used after every strobe is `WAIT_CYC`, the largest of the rest width, the recovery count and the synchronizer depth.

Top module: `pfifo_host_ctrl`

## Requirements
- R1: After reset, `rd_strobe_n` is 1, `wr_strobe` is 0, `bus_oe` is 0, `rx_valid` is 0 and `tx_ready` is 1.
- R2: A read strobe starts only when the synchronized receive flag is low (0 means data waiting) and no received byte is pending on the receive stream. While `rx_avail_n` is 1, no read strobe occurs.
- R3: A write sequence starts only when the synchronized transmit flag is low (0 means space available). While `tx_space_n` is 1, no write strobe occurs and the held byte is kept.
- R4: `rd_strobe_n` stays low for exactly `STROBE_ACT_CYC` cycles. The byte on `bus_in` is captured in the last low cycle and delivered on `rx_data` in the order the device supplied it.
- R5: `bus_oe` is never 1 while `rd_strobe_n` is 0.
- R6: For a write, `bus_oe` is 1 and `bus_out` holds the byte for at least one cycle before `wr_strobe` rises. `wr_strobe` stays high for exactly `STROBE_ACT_CYC` cycles, and `bus_oe` and `bus_out` stay unchanged for one cycle after `wr_strobe` falls. Bytes are committed in stream order.
- R7: Between the end of one strobe and the start of the next, neither strobe is active for at least `WAIT_CYC` cycles.
- R8: When a read and a write are both eligible in `ST_IDLE`, the controller grants the kind not served last. After reset, a read wins the first tie.
- R9: While `rx_valid` is 1 and `rx_ready` is 0, `rx_valid` and `rx_data` stay unchanged and no further read strobe starts.
- R10: The transmit stream has a one-byte holding register. `tx_ready` is 1 exactly when the register is empty, and the register empties when its write sequence ends.
- R11: The read strobe and the write strobe are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_in | input | DATA_W | Byte read from the shared bus pads |
| bus_out | output | DATA_W | Byte driven onto the shared bus during writes |
| bus_oe | output | 1 | Host bus driver enable |
| rx_avail_n | input | 1 | Device flag, low when received data is waiting (asynchronous) |
| tx_space_n | input | 1 | Device flag, low when a byte can be accepted (asynchronous) |
| rd_strobe_n | output | 1 | Read strobe, active low |
| wr_strobe | output | 1 | Write strobe, active high, commits on its falling edge |
| rx_data | output | DATA_W | Received byte |
| rx_valid | output | 1 | Received byte valid |
| rx_ready | input | 1 | Consumer accepts the received byte |
| tx_data | input | DATA_W | Byte to transmit |
| tx_valid | input | 1 | Byte to transmit is valid |
| tx_ready | output | 1 | Holding register can take a byte |

## Verification
The bench models the device: it serves bytes while the read strobe is low and commits the bus value on each falling write strobe. It targets these corner cases:

- **Flag held high for many cycles.** A design that ignored the synchronized flag would strobe into an empty or full device.
- **Receive consumer stalling.** A design that kept reading would overwrite an unconsumed byte or lose one.
- **Both directions eligible at once.** A fixed-priority design would show two reads or two writes in a row instead of strict alternation.
- **Strobe widths and gaps.** These are measured cycle by cycle, so an off-by-one timer load shows up as a strobe one cycle too short or too long, or as a gap below the recovery wait.
- **Bus direction.** A design that dropped `bus_oe` too early would commit a released bus, and one that drove the bus during a read would clash with the device.

// File: rtl/pfh_pkg.sv
package pfh_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_STROBE,
        ST_WR_SETUP,
        ST_WR_STROBE,
        ST_WR_HOLD,
        ST_RECOVER
    } pfh_state_e;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pfh_flag_sync.sv
module pfh_flag_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    localparam int unsigned DEPTH = (STAGES < 2) ? 2 : STAGES;

    // Flags are active low, so the reset value reads as "not ready".
    logic [DEPTH-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[DEPTH-2:0], async_i};
        end
    end

    assign sync_o = chain_q[DEPTH-1];

endmodule

// File: rtl/pfh_cycle_timer.sv
module pfh_cycle_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    // Loaded with N-1 on entry to a state, so the state lasts N cycles.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/pfh_rr_arbiter.sv
module pfh_rr_arbiter (
    input  logic clk,
    input  logic rst_n,
    input  logic want_rd,
    input  logic want_wr,
    input  logic commit,
    output logic grant_rd,
    output logic grant_wr
);
    // Starts as if a write was served last, so a read wins the first tie.
    logic last_wr_q;

    always_comb begin
        grant_rd = want_rd && (!want_wr || last_wr_q);
        grant_wr = want_wr && (!want_rd || !last_wr_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_wr_q <= 1'b1;
        end else if (commit) begin
            last_wr_q <= grant_wr;
        end
    end

endmodule

// File: rtl/pfifo_host_ctrl.sv
module pfifo_host_ctrl
    import pfh_pkg::*;
#(
    parameter int unsigned DATA_W          = 8,
    parameter int unsigned STROBE_ACT_CYC  = 2,
    parameter int unsigned STROBE_REST_CYC = 2,
    parameter int unsigned FLAG_RECOV_CYC  = 2,
    parameter int unsigned SYNC_STAGES     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    input  logic              rx_avail_n,
    input  logic              tx_space_n,
    output logic              rd_strobe_n,
    output logic              wr_strobe,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              rx_ready,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready
);
    // Every timing value is raised to at least 2 cycles.
    localparam int unsigned ACT_C   = max2(STROBE_ACT_CYC, 2);
    localparam int unsigned REST_C  = max2(STROBE_REST_CYC, 2);
    localparam int unsigned RECOV_C = max2(FLAG_RECOV_CYC, 2);
    localparam int unsigned SYNC_C  = max2(SYNC_STAGES, 2);
    localparam int unsigned WAIT_C  = max2(max2(REST_C, RECOV_C), SYNC_C);
    localparam int unsigned CNT_W   = $clog2(max2(ACT_C, WAIT_C) + 1);

    pfh_state_e state_q, state_d;

    logic             rx_avail_s_n;
    logic             tx_space_s_n;
    logic             timer_load;
    logic [CNT_W-1:0] timer_val;
    logic             timer_done;
    logic             want_rd, want_wr;
    logic             grant_rd, grant_wr;
    logic             arb_commit;
    logic             rx_capture;

    logic [DATA_W-1:0] rx_data_q;
    logic              rx_valid_q;
    logic [DATA_W-1:0] tx_hold_q;
    logic              tx_full_q;

    // Flag synchronizers
    pfh_flag_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_C)
    ) u_flag_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({tx_space_n, rx_avail_n}),
        .sync_o  ({tx_space_s_n, rx_avail_s_n})
    );

    // Shared phase timer
    pfh_cycle_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .load_val (timer_val),
        .expired  (timer_done)
    );

    // Eligibility and arbitration
    assign want_rd    = !rx_avail_s_n && !rx_valid_q;
    assign want_wr    = !tx_space_s_n && tx_full_q;
    assign arb_commit = (state_q == ST_IDLE) && (grant_rd || grant_wr);

    pfh_rr_arbiter u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .want_rd  (want_rd),
        .want_wr  (want_wr),
        .commit   (arb_commit),
        .grant_rd (grant_rd),
        .grant_wr (grant_wr)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and timer control
    always_comb begin
        state_d    = state_q;
        timer_load = 1'b0;
        timer_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (grant_rd) begin
                    state_d    = ST_RD_STROBE;
                    timer_load = 1'b1;
                    timer_val  = CNT_W'(ACT_C - 1);
                end else if (grant_wr) begin
                    state_d = ST_WR_SETUP;
                end
            end
            ST_RD_STROBE: begin
                if (timer_done) begin
                    state_d    = ST_RECOVER;
                    timer_load = 1'b1;
                    timer_val  = CNT_W'(WAIT_C - 1);
                end
            end
            ST_WR_SETUP: begin
                state_d    = ST_WR_STROBE;
                timer_load = 1'b1;
                timer_val  = CNT_W'(ACT_C - 1);
            end
            ST_WR_STROBE: begin
                if (timer_done) begin
                    state_d = ST_WR_HOLD;
                end
            end
            ST_WR_HOLD: begin
                state_d    = ST_RECOVER;
                timer_load = 1'b1;
                timer_val  = CNT_W'(WAIT_C - 1);
            end
            ST_RECOVER: begin
                if (timer_done) begin
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Port outputs decoded from the state
    always_comb begin
        rd_strobe_n = 1'b1;
        wr_strobe   = 1'b0;
        bus_oe      = 1'b0;
        unique case (state_q)
            ST_RD_STROBE: rd_strobe_n = 1'b0;
            ST_WR_SETUP:  bus_oe      = 1'b1;
            ST_WR_STROBE: begin
                bus_oe    = 1'b1;
                wr_strobe = 1'b1;
            end
            ST_WR_HOLD:   bus_oe      = 1'b1;
            ST_IDLE, ST_RECOVER: begin
                rd_strobe_n = 1'b1;
            end
            default: begin
                rd_strobe_n = 1'b1;
            end
        endcase
        bus_out = bus_oe ? tx_hold_q : '0;
    end

    // Receive register: capture in the last low cycle of the read strobe
    assign rx_capture = (state_q == ST_RD_STROBE) && timer_done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_valid_q <= 1'b0;
            rx_data_q  <= '0;
        end else if (rx_capture) begin
            rx_valid_q <= 1'b1;
            rx_data_q  <= bus_in;
        end else if (rx_ready) begin
            rx_valid_q <= 1'b0;
        end
    end

    // Transmit holding register: freed as the write sequence ends
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_full_q <= 1'b0;
            tx_hold_q <= '0;
        end else if (tx_valid && !tx_full_q) begin
            tx_full_q <= 1'b1;
            tx_hold_q <= tx_data;
        end else if (state_q == ST_WR_HOLD) begin
            tx_full_q <= 1'b0;
        end
    end

    assign rx_data  = rx_data_q;
    assign rx_valid = rx_valid_q;
    assign tx_ready = !tx_full_q;

endmodule

// File: rtl/pfh_checker.sv
module pfh_checker
    import pfh_pkg::*;
#(
    parameter int unsigned DATA_W          = 8,
    parameter int unsigned STROBE_ACT_CYC  = 2,
    parameter int unsigned STROBE_REST_CYC = 2,
    parameter int unsigned FLAG_RECOV_CYC  = 2,
    parameter int unsigned SYNC_STAGES     = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_strobe_n,
    input logic              wr_strobe,
    input logic              bus_oe,
    input logic [DATA_W-1:0] bus_out,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic [DATA_W-1:0] rx_data,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic              rx_flag_s_n,
    input logic              tx_flag_s_n
);
    localparam int unsigned ACT_C  = max2(STROBE_ACT_CYC, 2);
    localparam int unsigned WAIT_C = max2(max2(max2(STROBE_REST_CYC, 2), max2(FLAG_RECOV_CYC, 2)),
                                          max2(SYNC_STAGES, 2));
    localparam logic [7:0] ACT_V  = 8'(ACT_C);
    localparam logic [7:0] WAIT_V = 8'(WAIT_C);

    logic [7:0] rd_low_cnt, wr_high_cnt, quiet_cnt;

    function automatic logic [7:0] sat_inc(input logic [7:0] v);
        return (v == 8'hFF) ? v : v + 8'd1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_low_cnt  <= '0;
            wr_high_cnt <= '0;
            quiet_cnt   <= 8'hFF;
        end else begin
            rd_low_cnt  <= rd_strobe_n ? 8'd0 : sat_inc(rd_low_cnt);
            wr_high_cnt <= wr_strobe ? sat_inc(wr_high_cnt) : 8'd0;
            quiet_cnt   <= (rd_strobe_n && !wr_strobe) ? sat_inc(quiet_cnt) : 8'd0;
        end
    end

    AST_RD_FLAG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_strobe_n) |-> (!$past(rx_flag_s_n) && !$past(rx_valid))); // R2
    AST_WR_FLAG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_oe) |-> !$past(tx_flag_s_n)); // R3
    AST_RD_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_strobe_n) |-> (rd_low_cnt == ACT_V)); // R4
    AST_RD_BUS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe_n |-> !bus_oe); // R5
    AST_WR_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_strobe) |-> ($past(bus_oe) && $stable(bus_out))); // R6
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_strobe) |-> (bus_oe && $stable(bus_out))); // R6
    AST_WR_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_strobe) |-> (wr_high_cnt == ACT_V)); // R6
    AST_STROBE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rd_strobe_n) || $rose(wr_strobe)) |-> (quiet_cnt >= WAIT_V)); // R7
    AST_RX_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data))); // R9
    AST_TX_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready); // R10
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_strobe_n && wr_strobe)); // R11

endmodule

bind pfifo_host_ctrl pfh_checker #(
    .DATA_W          (DATA_W),
    .STROBE_ACT_CYC  (STROBE_ACT_CYC),
    .STROBE_REST_CYC (STROBE_REST_CYC),
    .FLAG_RECOV_CYC  (FLAG_RECOV_CYC),
    .SYNC_STAGES     (SYNC_STAGES)
) u_pfh_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_strobe_n (rd_strobe_n),
    .wr_strobe   (wr_strobe),
    .bus_oe      (bus_oe),
    .bus_out     (bus_out),
    .rx_valid    (rx_valid),
    .rx_ready    (rx_ready),
    .rx_data     (rx_data),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready),
    .rx_flag_s_n (rx_avail_s_n),
    .tx_flag_s_n (tx_space_s_n)
);

// File: tb/test_pfifo_host_ctrl.sv
`timescale 1ns/1ps
module test_pfifo_host_ctrl;
    localparam int ACT   = 3;
    localparam int REST  = 2;
    localparam int RECOV = 3;
    localparam int WAITC = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_in = 8'h00;
    logic [7:0] bus_out;
    logic       bus_oe;
    logic       rx_avail_n = 1'b1;
    logic       tx_space_n = 1'b1;
    logic       rd_n;
    logic       wr;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_ready = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_valid = 1'b0;
    logic       tx_ready;

    int checks = 0;
    int errors = 0;
    int rd_falls = 0;
    int wr_falls = 0;
    int rd_run = 0;
    int wr_run = 0;
    int quiet = 1000;
    bit dev_hold = 1'b1;

    logic [7:0] dev_q[$];
    logic [7:0] exp_rx[$];
    logic [7:0] exp_tx[$];
    int         order_q[$];

    always #2 clk = ~clk;

    pfifo_host_ctrl #(
        .DATA_W          (8),
        .STROBE_ACT_CYC  (ACT),
        .STROBE_REST_CYC (REST),
        .FLAG_RECOV_CYC  (RECOV),
        .SYNC_STAGES     (2)
    ) i_pfifo_host_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_in      (bus_in),
        .bus_out     (bus_out),
        .bus_oe      (bus_oe),
        .rx_avail_n  (rx_avail_n),
        .tx_space_n  (tx_space_n),
        .rd_strobe_n (rd_n),
        .wr_strobe   (wr),
        .rx_data     (rx_data),
        .rx_valid    (rx_valid),
        .rx_ready    (rx_ready),
        .tx_data     (tx_data),
        .tx_valid    (tx_valid),
        .tx_ready    (tx_ready)
    );

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic refresh_flag();
        rx_avail_n = dev_hold || (dev_q.size() == 0);
    endtask

    task automatic dev_load(input logic [7:0] b);
        dev_q.push_back(b);
        exp_rx.push_back(b);
        refresh_flag();
    endtask

    task automatic send_tx(input logic [7:0] b);
        @(posedge clk);
        #1;
        tx_data  = b;
        tx_valid = 1'b1;
        do @(negedge clk); while (!tx_ready);
        @(posedge clk);
        #1;
        tx_valid = 1'b0;
        exp_tx.push_back(b);
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // Device model: serve the head byte while the read strobe is low
    always @(negedge rd_n) begin
        if (rst_n) begin
            rd_falls++;
            order_q.push_back(0);
            if (dev_q.size() > 0) begin
                bus_in = dev_q[0];
            end else begin
                check(1'b0, "R2 read strobe with empty device", 1, 0);
            end
        end
    end

    always @(posedge rd_n) begin
        if (rst_n && dev_q.size() > 0) begin
            void'(dev_q.pop_front());
            refresh_flag();
        end
    end

    always @(posedge wr) begin
        if (rst_n) order_q.push_back(1);
    end

    // Device model: commit the bus value on the falling write strobe
    always @(negedge wr) begin
        if (rst_n) begin
            wr_falls++;
            check(bus_oe == 1'b1, "R6 bus driven at commit edge", int'(bus_oe), 1);
            if (exp_tx.size() > 0) begin
                check(bus_out == exp_tx[0], "R6 committed byte", int'(bus_out), int'(exp_tx[0]));
                void'(exp_tx.pop_front());
            end else begin
                check(1'b0, "R6 unexpected write", int'(bus_out), -1);
            end
        end
    end

    // Monitor: strobe widths, gaps, bus direction, receive scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (!rd_n) begin
                rd_run++;
                check(!bus_oe, "R5 host bus off during read", int'(bus_oe), 0);
            end else if (rd_run != 0) begin
                check(rd_run == ACT, "R4 read strobe width", rd_run, ACT);
                rd_run = 0;
            end
            if (wr) begin
                wr_run++;
            end else if (wr_run != 0) begin
                check(wr_run == ACT, "R6 write strobe width", wr_run, ACT);
                wr_run = 0;
            end
            if (!rd_n && wr) check(1'b0, "R11 both strobes active", 1, 0);
            if (rd_n && !wr) begin
                quiet++;
            end else begin
                if (quiet != 0) check(quiet >= WAITC, "R7 gap between strobes", quiet, WAITC);
                quiet = 0;
            end
            if (rx_valid && rx_ready) begin
                if (exp_rx.size() > 0) begin
                    check(rx_data == exp_rx[0], "R4 received byte order", int'(rx_data), int'(exp_rx[0]));
                    void'(exp_rx.pop_front());
                end else begin
                    check(1'b0, "R4 unexpected received byte", int'(rx_data), -1);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(rd_n == 1'b1, "R1 reset read strobe", int'(rd_n), 1);
        check(wr == 1'b0, "R1 reset write strobe", int'(wr), 0);
        check(bus_oe == 1'b0, "R1 reset bus enable", int'(bus_oe), 0);
        check(rx_valid == 1'b0, "R1 reset rx_valid", int'(rx_valid), 0);
        check(tx_ready == 1'b1, "R1 reset tx_ready", int'(tx_ready), 1);

        // Receive burst
        rx_ready = 1'b1;
        dev_hold = 1'b0;
        for (int i = 0; i < 4; i++) dev_load(8'(8'h13 + 8'h22 * i));
        wait_cycles(80);
        check(exp_rx.size() == 0, "R4 receive burst delivered", exp_rx.size(), 0);
        check(rd_falls == 4, "R2 one read per waiting byte", rd_falls, 4);

        // Transmit flag high blocks the write
        send_tx(8'hA5);
        wait_cycles(40);
        check(wr_falls == 0, "R3 no write while space flag high", wr_falls, 0);
        check(tx_ready == 1'b0, "R10 holding register full", int'(tx_ready), 0);
        tx_space_n = 1'b0;
        wait_cycles(40);
        check(wr_falls == 1, "R3 held byte written after release", wr_falls, 1);
        check(tx_ready == 1'b1, "R10 holding register freed", int'(tx_ready), 1);

        // Transmit burst
        for (int i = 0; i < 4; i++) send_tx(8'(8'h5A ^ (8'h11 * i)));
        wait_cycles(40);
        check(exp_tx.size() == 0, "R6 transmit burst committed", exp_tx.size(), 0);
        check(wr_falls == 5, "R6 write count", wr_falls, 5);

        // Receive flag high blocks reads
        dev_hold = 1'b1;
        refresh_flag();
        dev_load(8'hC3);
        dev_load(8'h3C);
        wait_cycles(40);
        check(rd_falls == 4, "R2 no read while receive flag high", rd_falls, 4);
        check(rx_valid == 1'b0, "R2 nothing received while blocked", int'(rx_valid), 0);
        dev_hold = 1'b0;
        refresh_flag();
        wait_cycles(60);
        check(exp_rx.size() == 0, "R2 bytes read after release", exp_rx.size(), 0);
        check(rd_falls == 6, "R2 read count after release", rd_falls, 6);

        // Consumer stall
        rx_ready = 1'b0;
        dev_load(8'h81);
        dev_load(8'h42);
        dev_load(8'h24);
        wait_cycles(40);
        check(rd_falls == 7, "R9 single read while byte pending", rd_falls, 7);
        check(rx_valid == 1'b1, "R9 byte held valid", int'(rx_valid), 1);
        check(rx_data == 8'h81, "R9 held byte value", int'(rx_data), 8'h81);
        rx_ready = 1'b1;
        wait_cycles(60);
        check(exp_rx.size() == 0, "R9 stalled bytes drained", exp_rx.size(), 0);
        check(rd_falls == 9, "R9 read count after drain", rd_falls, 9);

        // Both directions eligible at once
        dev_hold   = 1'b1;
        tx_space_n = 1'b1;
        refresh_flag();
        for (int i = 0; i < 4; i++) dev_load(8'(8'hE0 + i));
        send_tx(8'h70);
        wait_cycles(4);
        order_q.delete();
        fork
            begin
                for (int i = 1; i < 4; i++) send_tx(8'(8'h70 + i));
            end
            begin
                @(posedge clk);
                #1;
                dev_hold   = 1'b0;
                tx_space_n = 1'b0;
                refresh_flag();
            end
        join
        wait_cycles(80);
        check(order_q.size() == 8, "R8 strobe count in mixed traffic", order_q.size(), 8);
        for (int i = 1; i < order_q.size(); i++) begin
            check(order_q[i] != order_q[i-1], "R8 alternation between reads and writes",
                  order_q[i], 1 - order_q[i-1]);
        end
        check(exp_rx.size() == 0, "R4 mixed traffic received", exp_rx.size(), 0);
        check(exp_tx.size() == 0, "R6 mixed traffic written", exp_tx.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule